// File: doc/BRIEF.md
# Push-Pull PWM Controller with Output Steering

This block is a fully digital pulse-width modulator for push-pull or single-ended converter control. A free-running counter forms a sawtooth whose length is set by a period word. Every oscillator cycle opens with a blanking interval during which both drives are held low. After that interval, one pulse is produced while the counter is below the effective duty demand. The effective demand is the smaller of the demand input and a soft-start ceiling. A toggle flip-flop routes successive pulses to drive A and drive B in turn, so each drive runs at half the oscillator rate.

A pulse latch allows at most one pulse per cycle. The latch can be ended early by the cycle-by-cycle current-limit input or by the active-low shutdown input, and both of these force the drives low in the same clock cycle. An active-low sync input ends the running period and restarts the ramp, which lets the block follow a slightly faster external clock. An active-low soft-start reset holds the ceiling at zero. Once that reset is released, the ceiling climbs by a programmable step at every cycle boundary. The period, dead-time and step words are captured only at cycle boundaries.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: While rst_ni is low, out_a_o and out_b_o are low and the soft-start ceiling is zero.
- R2: out_a_o and out_b_o are never high together. Successive cycles that carry a pulse alternate between A (first) and B (second).
- R3: In each cycle, both drives are low for counts 0 to dead-1. A pulse begins at count dead.
- R4: A pulse ends at the first count that is not below min(demand, ceiling). If demand is at or below dead, the pulse width is zero. If demand exceeds the period, the pulse lasts until the end of the cycle (width period+1-dead).
- R5: A free-running cycle lasts period+1 clocks. cyc_start_o is high for exactly the first clock (count 0) of each cycle.
- R6: While shdn_ni is low, both drives are low in the same clock cycle. A pulse cut by shdn_ni does not resume in that cycle. The order of A and B is not disturbed.
- R7: While ilim_i is high, both drives are low in the same clock cycle. The cut pulse does not restart when ilim_i clears.
- R8: At most one rising drive edge occurs per cycle.
- R9: While ss_rst_ni is low, the ceiling is zero and so is the duty. After release, the ceiling (accumulator divided by 2^FRAC_W) rises by ss_step_i/2^FRAC_W per cycle until it saturates. Pulse widths therefore grow monotonically.
- R10: A low sample of sync_ni ends the cycle. The next clock is count 0 of a new cycle, and the drive side changes.
- R11: A change to period_i, dead_i or ss_step_i mid-cycle leaves the running cycle unchanged. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Cycle length minus one |
| dead_i | input | CNT_W | Blanking count at cycle start |
| demand_i | input | CNT_W | Duty demand compared with the ramp |
| ss_step_i | input | CNT_W | Ceiling increment per cycle, in 1/2^FRAC_W units |
| shdn_ni | input | 1 | Active-low immediate shutdown |
| sync_ni | input | 1 | Active-low period restart |
| ss_rst_ni | input | 1 | Active-low soft-start reset |
| ilim_i | input | 1 | Current-limit trip, ends present pulse |
| out_a_o | output | 1 | Drive A |
| out_b_o | output | 1 | Drive B |
| cyc_start_o | output | 1 | High on the first clock of each cycle |

## Verification
Several behaviours are checked by the assertions at every clock: the two drives never overlapping, the blanking interval, the same-cycle cut by shutdown and current limit, the limit of one rising edge per cycle, and the zero ceiling under soft-start reset. Other behaviours can only be shown by the directed scenarios, because they concern pulse widths, cycle lengths and ordering across several cycles. These include the alternation order, the width under different demands, the sync restart, the boundary-aligned update of configuration, the monotonic soft-start ramp, and the fact that the drive order survives a shutdown.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {
    PH_SPENT = 1'b0,
    PH_ARMED = 1'b1
  } pp_phase_e;
endpackage

// File: rtl/pp_ramp.sv
module pp_ramp #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             sync_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] dead_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, per_q, dead_q;
  logic             wrap;

  assign wrap = (cnt_q == per_q) || !sync_ni;

  // config captured only at a cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      dead_q <= '0;
    end else if (wrap) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      dead_q <= dead_i;
    end else begin
      cnt_q  <= cnt_q + ONE;
    end
  end

  assign cnt_o   = cnt_q;
  assign dead_o  = dead_q;
  assign wrap_o  = wrap;
  assign start_o = (cnt_q == '0);
endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_rst_ni,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] step_i,
  output logic [CNT_W-1:0] ceil_o
);
  localparam int ACC_W = CNT_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] step_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {{(FRAC_W+1){1'b0}}, step_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      step_q <= '0;
    end else begin
      if (wrap_i) step_q <= step_i;
      if (!ss_rst_ni)  acc_q <= '0;
      else if (wrap_i) acc_q <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end
  end

  assign ceil_o = acc_q[ACC_W-1 -: CNT_W];
endmodule

// File: rtl/pp_steer.sv
module pp_steer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] eff_i,
  input  logic             wrap_i,
  input  logic             ilim_i,
  input  logic             shdn_ni,
  output logic             out_a_o,
  output logic             out_b_o
);
  import pp_pwm_pkg::*;

  pp_phase_e phase_q;
  logic      sel_q;
  logic      past_dead, win, go, pulse;

  assign past_dead = (cnt_i >= dead_i);
  assign win       = past_dead && (cnt_i < eff_i);
  assign go        = win && !ilim_i && shdn_ni;
  assign pulse     = (phase_q == PH_ARMED) && go;

  // latch spends itself the first clock the window is not driving
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SPENT;
      sel_q   <= 1'b1;
    end else if (wrap_i) begin
      phase_q <= PH_ARMED;
      sel_q   <= ~sel_q;
    end else if (phase_q == PH_ARMED && past_dead && !go) begin
      phase_q <= PH_SPENT;
    end
  end

  assign out_a_o = pulse && !sel_q;
  assign out_b_o = pulse &&  sel_q;
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] demand_i,
  input  logic [CNT_W-1:0] ss_step_i,
  input  logic             shdn_ni,
  input  logic             sync_ni,
  input  logic             ss_rst_ni,
  input  logic             ilim_i,
  output logic             out_a_o,
  output logic             out_b_o,
  output logic             cyc_start_o
);
  logic [CNT_W-1:0] cnt, dead_cur, ceil, eff;
  logic             wrap;

  pp_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .dead_i  (dead_i),
    .sync_ni (sync_ni),
    .cnt_o   (cnt),
    .dead_o  (dead_cur),
    .wrap_o  (wrap),
    .start_o (cyc_start_o)
  );

  pp_softstart #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_ss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ss_rst_ni(ss_rst_ni),
    .wrap_i   (wrap),
    .step_i   (ss_step_i),
    .ceil_o   (ceil)
  );

  assign eff = (demand_i < ceil) ? demand_i : ceil;

  pp_steer #(.CNT_W(CNT_W)) u_steer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .dead_i (dead_cur),
    .eff_i  (eff),
    .wrap_i (wrap),
    .ilim_i (ilim_i),
    .shdn_ni(shdn_ni),
    .out_a_o(out_a_o),
    .out_b_o(out_b_o)
  );
endmodule

// File: rtl/pp_pwm_ctrl_chk.sv
module pp_pwm_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shdn_ni,
  input logic             ilim_i,
  input logic             ss_rst_ni,
  input logic             out_a_o,
  input logic             out_b_o,
  input logic             cyc_start_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] dead_i,
  input logic [CNT_W-1:0] ceil_i
);
  logic       prev_q, rise, drv;
  logic [1:0] rises_q;

  assign drv  = out_a_o || out_b_o;
  assign rise = drv && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      rises_q <= 2'd0;
    end else begin
      prev_q <= drv;
      if (cyc_start_o)                 rises_q <= {1'b0, rise};
      else if (rise && rises_q != 2'd3) rises_q <= rises_q + 2'd1;
    end
  end

  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_a_o && out_b_o));

  assert_dead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < dead_i) |-> (!out_a_o && !out_b_o));

  assert_shdn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |-> (!out_a_o && !out_b_o));

  assert_ilim_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |-> (!out_a_o && !out_b_o));

  assert_one_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !cyc_start_o) |-> (rises_q == 2'd0));

  assert_ss_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_rst_ni |=> (ceil_i == '0));
endmodule

bind pp_pwm_ctrl pp_pwm_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_ni    (shdn_ni),
  .ilim_i     (ilim_i),
  .ss_rst_ni  (ss_rst_ni),
  .out_a_o    (out_a_o),
  .out_b_o    (out_b_o),
  .cyc_start_o(cyc_start_o),
  .cnt_i      (cnt),
  .dead_i     (dead_cur),
  .ceil_i     (ceil)
);

// File: tb/test_pp_pwm_ctrl.sv
module test_pp_pwm_ctrl;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = 8'd19, dead_i = 8'd3, demand_i = 8'd10, ss_step_i = 8'd255;
  logic shdn_ni = 1'b1, sync_ni = 1'b1, ss_rst_ni = 1'b1, ilim_i = 1'b0;
  logic out_a_o, out_b_o, cyc_start_o;

  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  pp_pwm_ctrl i_pp_pwm_ctrl (
    .clk_i, .rst_ni, .period_i, .dead_i, .demand_i, .ss_step_i,
    .shdn_ni, .sync_ni, .ss_rst_ni, .ilim_i,
    .out_a_o, .out_b_o, .cyc_start_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    int n = 0;
    @(negedge clk_i);
    while (!cyc_start_o && n < 600) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  // At a negedge with cyc_start_o high: run one cycle, ending at the next start.
  // kind: 0 none, 1 shutdown, 2 current limit, 3 sync, 4 period change to 9
  task automatic run_cycle(input int act_idx, input int kind,
                           output int na, output int nb, output int first,
                           output int len, output int imm);
    int i = 0;
    na = 0; nb = 0; first = -1; imm = 0;
    do begin
      if (out_a_o) na++;
      if (out_b_o) nb++;
      if ((out_a_o || out_b_o) && first < 0) first = i;
      if (i == act_idx) begin
        case (kind)
          1: shdn_ni = 1'b0;
          2: ilim_i = 1'b1;
          3: sync_ni = 1'b0;
          4: period_i = 8'd9;
          default: ;
        endcase
        if (kind == 1 || kind == 2) begin
          #1;
          imm = int'(out_a_o) + int'(out_b_o);
        end
      end
      if (i == act_idx + 1) begin
        shdn_ni = 1'b1;
        ilim_i  = 1'b0;
      end
      @(negedge clk_i);
      i++;
    end while (!cyc_start_o && i < 600);
    len = i;
    shdn_ni = 1'b1;
    ilim_i  = 1'b0;
    sync_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!out_a_o && !out_b_o, "R1 outputs low in reset", int'(out_a_o | out_b_o), 0);
    rst_ni = 1'b1;
    wait_start();
  endtask

  task automatic settle();
    int na, nb, f, l, im;
    repeat (3) run_cycle(-1, 0, na, nb, f, l, im);
  endtask

  task automatic t_basic();
    int na, nb, f, l, im;
    int prev_a = -1;
    for (int c = 0; c < 4; c++) begin
      run_cycle(-1, 0, na, nb, f, l, im);
      check(l == 20, "R5 cycle length", l, 20);
      check(na + nb == 7, "R4 pulse width demand 10 dead 3", na + nb, 7);
      check(na == 0 || nb == 0, "R2 one side per cycle", na * nb, 0);
      check(f == 3, "R3 pulse begins at dead count", f, 3);
      if (prev_a >= 0) check((na > 0) != (prev_a > 0), "R2 alternation", na, 7 - prev_a);
      prev_a = na;
    end
  endtask

  task automatic t_zero_and_full();
    int na, nb, f, l, im;
    demand_i = 8'd3;
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 0, "R4 demand at dead gives zero", na + nb, 0);
    demand_i = 8'd1;
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 0, "R4 demand below dead gives zero", na + nb, 0);
    demand_i = 8'd200;
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 17, "R4 demand over period runs to end", na + nb, 17);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(f == 3, "R3 gap after full-width pulse", f, 3);
    demand_i = 8'd10;
    run_cycle(-1, 0, na, nb, f, l, im);
  endtask

  task automatic t_shutdown();
    int na, nb, f, l, im, a0;
    run_cycle(-1, 0, na, nb, f, l, im);
    a0 = na;
    run_cycle(5, 1, na, nb, f, l, im);
    check(im == 0, "R6 shutdown cuts same cycle", im, 0);
    check(na + nb == 3, "R6 no resume after shutdown release", na + nb, 3);
    check((na > 0) != (a0 > 0), "R6 side during shutdown cycle", na, 3 * int'(a0 == 0));
    run_cycle(-1, 0, na, nb, f, l, im);
    check((na > 0) == (a0 > 0), "R6 order kept after shutdown", na, 7 * int'(a0 > 0));
    check(na + nb == 7, "R6 full width next cycle", na + nb, 7);
  endtask

  task automatic t_ilim();
    int na, nb, f, l, im;
    run_cycle(5, 2, na, nb, f, l, im);
    check(im == 0, "R7 current limit cuts same cycle", im, 0);
    check(na + nb == 3, "R7 R8 no restart after trip clears", na + nb, 3);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 7, "R7 next cycle unaffected", na + nb, 7);
  endtask

  task automatic t_sync();
    int na, nb, f, l, im, a0;
    run_cycle(8, 3, na, nb, f, l, im);
    a0 = na;
    check(l == 9, "R10 sync shortens cycle", l, 9);
    check(na + nb == 6, "R10 pulse up to sync", na + nb, 6);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(l == 20, "R10 free-run after sync", l, 20);
    check((na > 0) != (a0 > 0), "R10 side changes after sync", na, 7 * int'(a0 == 0));
  endtask

  task automatic t_cfg();
    int na, nb, f, l, im;
    run_cycle(5, 4, na, nb, f, l, im);
    check(l == 20, "R11 running cycle keeps old period", l, 20);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(l == 10, "R11 new period next cycle", l, 10);
    check(na + nb == 7, "R11 width under new period", na + nb, 7);
    period_i = 8'd19;
    run_cycle(-1, 0, na, nb, f, l, im);
    check(l == 10, "R11 restore waits for boundary", l, 10);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(l == 20, "R11 restored period", l, 20);
  endtask

  task automatic t_softstart();
    int na, nb, f, l, im, w, prev;
    bit mono = 1'b1;
    ss_step_i = 8'd16;
    ss_rst_ni = 1'b0;
    run_cycle(-1, 0, na, nb, f, l, im);
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 0, "R9 zero duty under soft-start reset", na + nb, 0);
    ss_rst_ni = 1'b1;
    run_cycle(-1, 0, na, nb, f, l, im);
    check(na + nb == 0, "R9 first cycle after release zero", na + nb, 0);
    prev = 0;
    for (int c = 0; c < 14; c++) begin
      run_cycle(-1, 0, na, nb, f, l, im);
      w = na + nb;
      if (w < prev || w > prev + 1) mono = 1'b0;
      prev = w;
    end
    check(mono, "R9 width rises one count per cycle at most", int'(mono), 1);
    check(prev == 7, "R9 ramp reaches demand", prev, 7);
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    settle();
    t_basic();
    t_zero_and_full();
    t_shutdown();
    t_ilim();
    t_sync();
    t_cfg();
    t_softstart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule